// File: doc/BRIEF.md
# Multi-Chain Averaging Time-to-Digital Converter Back-End

This block is the digital back-end of a fine-time measurement unit in which one hit edge runs down several parallel tapped delay lines at once. Adjacent lines are offset from each other by a fixed delay. Each line therefore latches a thermometer-style tap snapshot that is shifted slightly against its neighbours. All snapshots are taken on the same clock edge. The block turns each snapshot into its own fine code, adds the codes in an adder tree, and reports the average. The average keeps log2(chain count) fractional bits, so the effective bin is finer than one delay cell.

A coarse clock-counter value is captured with the hit and placed in the upper part of the output timestamp. The averaged fine value fills the lower part. A result is produced two cycles after the hit. The pipeline accepts at most one hit every other cycle. A hit that arrives while the previous one is still in the first stage is discarded, and the discard is reported with a one-cycle pulse.

Top module: `mc_tdc_backend`

## Requirements
- R1: The fine code of one chain is the position of its highest set tap plus one (tap index 0 is the first tap the hit reaches). A chain with no tap set has code 0. Cleared taps below the highest set tap (bubbles) do not change the code.
- R2: The fine field of the timestamp is `out_ts_o[SUM_W-1:0]`, where SUM_W = FINE_W + log2(N_CHAINS) and FINE_W = clog2(N_TAPS+1). It holds the sum of all chain codes. Read as a fixed-point number, it is their average with log2(N_CHAINS) fractional bits in the lowest bits.
- R3: The upper COARSE_W bits of `out_ts_o` hold the value of `coarse_i` sampled on the same clock edge as the accepted hit.
- R4: A hit that is presented in cycle c and accepted on the edge closing cycle c gives an `out_vld_o` pulse in cycle c+2, lasting exactly one cycle.
- R5: A hit presented in the cycle right after an accepted hit is dropped. It produces no result. `hit_drop_o` is high for one cycle, in the cycle after the dropped hit.
- R6: While `out_vld_o` is low, `out_ts_o` keeps its last value. Tap vectors and the coarse value presented without `hit_vld_i` have no effect.
- R7: During and after reset, `out_vld_o`, `hit_drop_o` and `out_ts_o` are all zero.
- R8: With every tap of every chain set, the fine field equals N_CHAINS*N_TAPS (512 with the defaults), with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_vld_i | input | 1 | The tap snapshots on this edge belong to a hit |
| taps_i | input | N_CHAINS*N_TAPS | Tap snapshots; chain j occupies bits [j*N_TAPS +: N_TAPS] |
| coarse_i | input | COARSE_W | Coarse clock-counter value |
| out_vld_o | output | 1 | One-cycle strobe: timestamp valid |
| out_ts_o | output | COARSE_W+SUM_W | {coarse, summed fine code} |
| hit_drop_o | output | 1 | One-cycle pulse: a hit was discarded |

## Verification
A hit sampled at the end of cycle c has its timestamp and valid strobe due in cycle c+2. A drop pulse is due in cycle c+1 after a hit that was rejected in cycle c. The bench reference model advances on each rising edge in the same way. It compares strobe, drop flag and timestamp half a cycle later, on the falling edge, so every result is checked in exactly the cycle it is due. Directed hits with known tap patterns are checked once more, one edge after the stage in which their result must appear. Hit patterns on back-to-back cycles, alternate cycles and sparse cycles cover both acceptance and dropping.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
   // bits needed to hold a code in 0..taps
   function automatic int unsigned code_bits(input int unsigned taps);
      return $clog2(taps + 1);
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tdc_therm_enc.sv
module tdc_therm_enc #(
   parameter int unsigned N_TAPS = 64,
   localparam int unsigned CODE_W = tdc_pkg::code_bits(N_TAPS)
) (
   input  logic [N_TAPS-1:0] taps_i,
   output logic [CODE_W-1:0] code_o
);
   // R1: highest set tap wins; bubbles underneath are irrelevant
   always_comb begin
      code_o = '0;
      for (int t = 0; t < N_TAPS; t++) begin
         if (taps_i[t]) code_o = CODE_W'(t + 1);
      end
   end
endmodule

// File: rtl/tdc_adder_tree.sv
module tdc_adder_tree #(
   parameter int unsigned N_IN  = 8,
   parameter int unsigned IN_W  = 7,
   parameter int unsigned OUT_W = 10
) (
   input  logic [N_IN*IN_W-1:0] in_flat_i,
   output logic [OUT_W-1:0]     sum_o
);
   localparam int unsigned N_NODE = 2 * N_IN - 1;

   if (!tdc_pkg::is_pow2(N_IN)) begin : g_bad_n
      $error("adder tree needs a power-of-two input count");
   end
   if (OUT_W < IN_W + $clog2(N_IN)) begin : g_bad_w
      $error("adder tree output too narrow");
   end

   logic [OUT_W-1:0] node [N_NODE];

   // heap layout: leaves at N_IN-1 .. 2*N_IN-2, root at 0
   for (genvar i = 0; i < N_IN; i++) begin : g_leaf
      assign node[N_IN - 1 + i] = OUT_W'(in_flat_i[i*IN_W +: IN_W]);
   end
   for (genvar i = 0; i < N_IN - 1; i++) begin : g_add
      assign node[i] = node[2*i + 1] + node[2*i + 2];
   end

   assign sum_o = node[0];
endmodule

// File: rtl/mc_tdc_backend.sv
module mc_tdc_backend #(
   parameter int unsigned N_CHAINS = 8,
   parameter int unsigned N_TAPS   = 64,
   parameter int unsigned COARSE_W = 16,
   localparam int unsigned FINE_W  = tdc_pkg::code_bits(N_TAPS),
   localparam int unsigned FRAC_W  = $clog2(N_CHAINS),
   localparam int unsigned SUM_W   = FINE_W + FRAC_W,
   localparam int unsigned TS_W    = COARSE_W + SUM_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hit_vld_i,
   input  logic [N_CHAINS*N_TAPS-1:0] taps_i,
   input  logic [COARSE_W-1:0]        coarse_i,
   output logic                       out_vld_o,
   output logic [TS_W-1:0]            out_ts_o,
   output logic                       hit_drop_o
);
   if (!tdc_pkg::is_pow2(N_CHAINS)) begin : g_bad_chains
      $error("N_CHAINS must be a power of two, at least 2");
   end
   if (N_TAPS < 2) begin : g_bad_taps
      $error("N_TAPS must be at least 2");
   end
   if (COARSE_W < 1) begin : g_bad_coarse
      $error("COARSE_W must be at least 1");
   end

   // per-chain encoders
   logic [N_CHAINS*FINE_W-1:0] codes;
   for (genvar j = 0; j < N_CHAINS; j++) begin : g_chain
      tdc_therm_enc #(.N_TAPS(N_TAPS)) u_enc (
         .taps_i (taps_i[j*N_TAPS +: N_TAPS]),
         .code_o (codes[j*FINE_W +: FINE_W])
      );
   end

   // stage 1: encoded codes and coarse time
   logic                       s1_vld_q;
   logic [N_CHAINS*FINE_W-1:0] s1_codes_q;
   logic [COARSE_W-1:0]        s1_coarse_q;
   logic                       accept;

   assign accept = hit_vld_i && !s1_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld_q    <= 1'b0;
         s1_codes_q  <= '0;
         s1_coarse_q <= '0;
         hit_drop_o  <= 1'b0;
      end else begin
         s1_vld_q   <= accept;
         hit_drop_o <= hit_vld_i && s1_vld_q;
         if (accept) begin
            s1_codes_q  <= codes;
            s1_coarse_q <= coarse_i;
         end
      end
   end

   // stage 2: summation and output register
   logic [SUM_W-1:0] sum;

   tdc_adder_tree #(
      .N_IN  (N_CHAINS),
      .IN_W  (FINE_W),
      .OUT_W (SUM_W)
   ) u_tree (
      .in_flat_i (s1_codes_q),
      .sum_o     (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld_o <= 1'b0;
         out_ts_o  <= '0;
      end else begin
         out_vld_o <= s1_vld_q;
         if (s1_vld_q) out_ts_o <= {s1_coarse_q, sum};
      end
   end

   // assertions
   a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vld_i && !s1_vld_q) |=> ##1 out_vld_o);

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |=> !out_vld_o);

   a_r5_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vld_i && s1_vld_q) |=> hit_drop_o);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld_o |-> $stable(out_ts_o));

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> (out_ts_o[SUM_W-1:0] <= SUM_W'(N_CHAINS * N_TAPS)));

   a_r3_coarse: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vld_i && !s1_vld_q) |=> ##1 (out_ts_o[TS_W-1 -: COARSE_W] == $past(coarse_i, 2)));
endmodule

// File: tb/tb_mc_tdc_backend.sv
`timescale 1ns/1ps
module tb_mc_tdc_backend;
   localparam int NC = 8;
   localparam int NT = 64;
   localparam int CW = 16;
   localparam int SW = 10;
   localparam int TW = CW + SW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            hit_vld_i = 1'b0;
   logic [NC*NT-1:0] taps_i = '0;
   logic [CW-1:0]   coarse_i = '0;
   logic            out_vld_o;
   logic [TW-1:0]   out_ts_o;
   logic            hit_drop_o;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   mc_tdc_backend #(.N_CHAINS(NC), .N_TAPS(NT), .COARSE_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .hit_vld_i(hit_vld_i), .taps_i(taps_i),
      .coarse_i(coarse_i), .out_vld_o(out_vld_o), .out_ts_o(out_ts_o),
      .hit_drop_o(hit_drop_o)
   );

   // reference model state
   bit            m_s1_vld, m_out_vld, m_drop;
   int            m_s1_sum;
   int            m_s1_coarse;
   logic [TW-1:0] m_ts;

   function automatic int ref_code(input logic [NT-1:0] v);
      for (int t = NT - 1; t >= 0; t--) if (v[t] === 1'b1) return t + 1;
      return 0;
   endfunction

   function automatic int ref_sum(input logic [NC*NT-1:0] v);
      int s = 0;
      for (int j = 0; j < NC; j++) s += ref_code(v[j*NT +: NT]);
      return s;
   endfunction

   function automatic logic [NT-1:0] therm(input int len, input bit bub);
      logic [NT-1:0] v = '0;
      for (int t = 0; t < len; t++) v[t] = 1'b1;
      if (bub && len > 2) v[$urandom % (len - 1)] = 1'b0;
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1_vld = 0; m_out_vld = 0; m_drop = 0; m_ts = '0;
         m_s1_sum = 0; m_s1_coarse = 0;
      end else begin
         m_out_vld = m_s1_vld;
         if (m_s1_vld) m_ts = {CW'(m_s1_coarse), SW'(m_s1_sum)};
         m_drop = hit_vld_i && m_s1_vld;
         if (hit_vld_i && !m_s1_vld) begin
            m_s1_vld    = 1;
            m_s1_sum    = ref_sum(taps_i);
            m_s1_coarse = int'(coarse_i);
         end else begin
            m_s1_vld = 0;
         end
      end
   end

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", what, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      check(out_vld_o === m_out_vld, "R4 out_vld", out_vld_o, m_out_vld);
      check(hit_drop_o === m_drop, "R5 hit_drop", hit_drop_o, m_drop);
      if (m_out_vld) begin
         check(out_ts_o[SW-1:0] === m_ts[SW-1:0], "R1 R2 fine sum", out_ts_o[SW-1:0], m_ts[SW-1:0]);
         check(out_ts_o[TW-1:SW] === m_ts[TW-1:SW], "R3 coarse", out_ts_o[TW-1:SW], m_ts[TW-1:SW]);
      end else begin
         check(out_ts_o === m_ts, "R6 hold", out_ts_o, m_ts);
      end
   endtask

   // one cycle: compare at the falling edge, then drive the next inputs
   task automatic step(input bit hv, input logic [NC*NT-1:0] t);
      @(negedge clk);
      compare_model();
      hit_vld_i = hv;
      taps_i    = t;
      coarse_i  = coarse_i + 1'b1;
   endtask

   function automatic logic [NC*NT-1:0] rand_taps(input bit bub);
      logic [NC*NT-1:0] v;
      for (int j = 0; j < NC; j++) v[j*NT +: NT] = therm($urandom % (NT + 1), bub);
      return v;
   endfunction

   function automatic logic [NC*NT-1:0] noise();
      logic [NC*NT-1:0] v;
      for (int w = 0; w < NC*NT/32; w++) v[w*32 +: 32] = $urandom;
      return v;
   endfunction

   // directed hit with a known fine sum, checked in cycle c+2
   task automatic directed(input logic [NC*NT-1:0] t, input int exp, input string tag);
      logic [CW-1:0] c;
      step(1'b1, t);
      c = coarse_i;
      step(1'b0, noise());
      @(posedge clk); #2;
      check(out_vld_o === 1'b1, {tag, " valid"}, out_vld_o, 1);
      check(out_ts_o[SW-1:0] === SW'(exp), {tag, " fine"}, out_ts_o[SW-1:0], exp);
      check(out_ts_o[TW-1:SW] === c, "R3 coarse directed", out_ts_o[TW-1:SW], c);
   endtask

   initial begin
      #(20.0 * 200000);
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [NC*NT-1:0] t;
      repeat (3) @(negedge clk);
      // R7 reset state
      check(out_vld_o === 1'b0, "R7 out_vld reset", out_vld_o, 0);
      check(hit_drop_o === 1'b0, "R7 drop reset", hit_drop_o, 0);
      check(out_ts_o === '0, "R7 ts reset", out_ts_o, 0);
      hit_vld_i = 1'b1; taps_i = noise();
      @(negedge clk);
      check(out_vld_o === 1'b0, "R7 no output in reset", out_vld_o, 0);
      hit_vld_i = 1'b0;
      rst_n = 1'b1;
      step(1'b0, '0);
      step(1'b0, '0);

      // R1 R2: chain j holds 10+j taps -> 8*10+28 = 108
      for (int j = 0; j < NC; j++) t[j*NT +: NT] = therm(10 + j, 0);
      directed(t, 108, "R2 staircase");
      // R1: bubbles below the top tap; 4'b1011 per chain -> code 4 each
      t = '0;
      for (int j = 0; j < NC; j++) t[j*NT +: 4] = 4'b1011;
      directed(t, 32, "R1 bubble");
      // R1: empty chains
      directed('0, 0, "R1 empty");
      // R8: all taps set -> 512
      directed('1, NC * NT, "R8 full");
      // R6: idle cycles with noise leave the timestamp unchanged
      for (int i = 0; i < 20; i++) step(1'b0, noise());
      // R5: back-to-back hits
      for (int i = 0; i < 300; i++) step(1'b1, rand_taps(i[0]));
      // alternate-cycle hits, all accepted
      for (int i = 0; i < 600; i++) step(i[0] == 1'b0, (i[0] == 1'b0) ? rand_taps(1) : noise());
      // sparse random hits
      for (int i = 0; i < 1500; i++) step(($urandom % 4) == 0, rand_taps($urandom % 2));
      for (int i = 0; i < 4; i++) step(1'b0, '0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule